// File: doc/BRIEF.md
# Framed Address/Data Serial Port

This block is the serial link between a converter front end and its host processor. It runs full duplex. It makes the serial clock itself by dividing the system clock, and it drives the output frame sync. The host supplies the input frame sync. In both directions a transfer is a pair of 16-bit words, address then data, each sent most significant bit first. Each word is introduced by its own frame sync.

On the output side there are two sources of pairs: converter samples and resampled samples. Each source has one pending slot. When both slots hold a pair, the converter pair is sent first. A pair that has started always goes out whole, unless chip select drops. On the input side, each complete address/data pair is handed to a register bank as a single write pulse.

Chip select low disables the pins and makes the block ignore its inputs. Reset low does the same.

Top module: `fsp_serial_port`

## Requirements
- R1: `sclk_o` has a period of 2*HALF_DIV system clocks, high for HALF_DIV and low for HALF_DIV. While chip select stays high, `sdo_o` and `sdofs_o` change only together with a rising edge of `sclk_o`.
- R2: An output pair looks like this. `sdofs_o` is high for one serial cycle. In the next 16 serial cycles the address goes out MSB first. `sdofs_o` is high again during the address LSB cycle. In the next 16 cycles the data goes out MSB first. `sdofs_o` is low during every other bit cycle.
- R3: `sdifs_i` and `sdi_i` are sampled on falling edges of `sclk_o`. The address MSB is taken on the falling edge after the one that saw the sync. After the data LSB, `wr_valid_o` pulses for one system clock, with the pair on `wr_addr_o`/`wr_data_o`.
- R4: After an address word, the data word starts on the next falling edge if a sync was seen during the address LSB cycle. Otherwise the block waits for a later sync. A sync seen during bits 0 to 14 of any word is held and takes effect only at that word's LSB. A sync at the data LSB starts a new address word directly.
- R5: When both slots are pending at a start opportunity, the converter pair is sent first. A pair in progress is never interrupted by a newly posted pair.
- R6: Each source keeps one pending pair. A new pair from a source replaces that source's unsent pair.
- R7: No output pair starts while `pwr_up_i` is low. Pending pairs are kept and are sent once it rises.
- R8: While `cs_i` is low, `out_en_o` is low and serial inputs are ignored. A word in progress in either direction is discarded.
- R9: While `rst_n` is low, `out_en_o` is low, `wr_valid_o` is low and both directions are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| pwr_up_i | input | 1 | Digital power-up; permits output pairs |
| adc_valid_i | input | 1 | Converter pair strobe |
| adc_addr_i | input | WORD_W | Converter pair address |
| adc_data_i | input | WORD_W | Converter pair data |
| rsm_valid_i | input | 1 | Resampler pair strobe |
| rsm_addr_i | input | WORD_W | Resampler pair address |
| rsm_data_i | input | WORD_W | Resampler pair data |
| sdi_i | input | 1 | Serial data from host |
| sdifs_i | input | 1 | Input frame sync from host |
| sclk_o | output | 1 | Generated serial clock |
| sdo_o | output | 1 | Serial data to host |
| sdofs_o | output | 1 | Output frame sync |
| out_en_o | output | 1 | Output enable for sclk/sdo/sdofs pins |
| wr_valid_o | output | 1 | Received pair strobe |
| wr_addr_o | output | WORD_W | Received address |
| wr_data_o | output | WORD_W | Received data |

## Verification
Input pairs are sent with the second sync placed at each kind of position. Some have it exactly at the address LSB. Some have it early inside the address word, where it must be held. Some have it after a gap of idle cycles. Some are chained with the next pair through a sync at the data LSB or a sync held from inside the data word. A wrong address/data split in any of these cases shows up as bad received words. Output patterns cover the following: a pair posted while power-up is low, both sources posted together, a source posted twice before sending, a second source posted mid-pair, and chip select dropped mid-pair. These show the effect of priority, overwrite, gating and abort separately.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_ADDR, RX_WAIT, RX_DATA} rx_state_e;
    typedef enum logic {TX_IDLE, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/fsp_sclk_gen.sv
module fsp_sclk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == CW'(HALF_DIV - 1));
        if (wrap) begin
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Event strobes are true in the cycle whose closing edge moves sclk.
    assign rise_o = wrap & ~s_q.sclk;
    assign fall_o = wrap &  s_q.sclk;
    assign sclk_o = s_q.sclk;
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
    import fsp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              cs_i,
    input  logic              pwr_up_i,
    input  logic              adc_valid_i,
    input  logic [WORD_W-1:0] adc_addr_i,
    input  logic [WORD_W-1:0] adc_data_i,
    input  logic              rsm_valid_i,
    input  logic [WORD_W-1:0] rsm_addr_i,
    input  logic [WORD_W-1:0] rsm_data_i,
    output logic              sdo_o,
    output logic              sdofs_o,
    output logic              busy_o,
    output logic              adc_pend_o,
    output logic              src_adc_o
);
    localparam int PAIR_W = 2 * WORD_W;
    localparam int CNT_W  = $clog2(PAIR_W + 1);

    typedef struct packed {
        tx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [PAIR_W-1:0]  sh;
        logic               sdo;
        logic               sdofs;
        logic               adc_pend;
        logic [PAIR_W-1:0]  adc_pair;
        logic               rsm_pend;
        logic [PAIR_W-1:0]  rsm_pair;
        logic               src_adc;
    } tx_t;

    tx_t s_d, s_q;
    logic take_adc, take_rsm;

    always_comb begin
        s_d      = s_q;
        take_adc = 1'b0;
        take_rsm = 1'b0;
        if (!cs_i) begin
            s_d.st    = TX_IDLE;
            s_d.cnt   = '0;
            s_d.sdo   = 1'b0;
            s_d.sdofs = 1'b0;
        end else if (rise_i) begin
            unique case (s_q.st)
                TX_IDLE: begin
                    s_d.sdo   = 1'b0;
                    s_d.sdofs = 1'b0;
                    if (pwr_up_i && (s_q.adc_pend || s_q.rsm_pend)) begin
                        s_d.st    = TX_SHIFT;
                        s_d.cnt   = '0;
                        s_d.sdofs = 1'b1;
                        if (s_q.adc_pend) begin
                            s_d.sh      = s_q.adc_pair;
                            s_d.src_adc = 1'b1;
                            take_adc    = 1'b1;
                        end else begin
                            s_d.sh      = s_q.rsm_pair;
                            s_d.src_adc = 1'b0;
                            take_rsm    = 1'b1;
                        end
                    end
                end
                TX_SHIFT: begin
                    if (s_q.cnt == CNT_W'(PAIR_W)) begin
                        s_d.st    = TX_IDLE;
                        s_d.sdo   = 1'b0;
                        s_d.sdofs = 1'b0;
                    end else begin
                        s_d.sdo   = s_q.sh[PAIR_W-1];
                        s_d.sh    = {s_q.sh[PAIR_W-2:0], 1'b0};
                        s_d.sdofs = (s_q.cnt == CNT_W'(WORD_W - 1));
                        s_d.cnt   = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = TX_IDLE;
            endcase
        end
        // Pending slots: a fresh pair wins over the clear of a take.
        if (take_adc) s_d.adc_pend = 1'b0;
        if (take_rsm) s_d.rsm_pend = 1'b0;
        if (adc_valid_i) begin
            s_d.adc_pend = 1'b1;
            s_d.adc_pair = {adc_addr_i, adc_data_i};
        end
        if (rsm_valid_i) begin
            s_d.rsm_pend = 1'b1;
            s_d.rsm_pair = {rsm_addr_i, rsm_data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo_o      = s_q.sdo;
    assign sdofs_o    = s_q.sdofs;
    assign busy_o     = (s_q.st == TX_SHIFT);
    assign adc_pend_o = s_q.adc_pend;
    assign src_adc_o  = s_q.src_adc;
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
    import fsp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              cs_i,
    input  logic              sdi_i,
    input  logic              sdifs_i,
    output logic              wr_valid_o,
    output logic [WORD_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o
);
    localparam int CW = $clog2(WORD_W);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              pend;
        logic              wr;
    } rx_t;

    rx_t s_d, s_q;
    logic              last, sync_now;
    logic [WORD_W-1:0] nsh;

    always_comb begin
        s_d      = s_q;
        s_d.wr   = 1'b0;
        last     = (s_q.cnt == CW'(WORD_W - 1));
        sync_now = sdifs_i | s_q.pend;
        nsh      = {s_q.sh[WORD_W-2:0], sdi_i};
        if (!cs_i) begin
            s_d.st   = RX_IDLE;
            s_d.cnt  = '0;
            s_d.pend = 1'b0;
        end else if (fall_i) begin
            unique case (s_q.st)
                RX_IDLE: if (sdifs_i) begin
                    s_d.st  = RX_ADDR;
                    s_d.cnt = '0;
                end
                RX_WAIT: if (sdifs_i) begin
                    s_d.st  = RX_DATA;
                    s_d.cnt = '0;
                end
                RX_ADDR, RX_DATA: begin
                    s_d.sh = nsh;
                    if (last) begin
                        s_d.cnt  = '0;
                        s_d.pend = 1'b0;
                        if (s_q.st == RX_ADDR) begin
                            s_d.addr = nsh;
                            s_d.st   = sync_now ? RX_DATA : RX_WAIT;
                        end else begin
                            s_d.data = nsh;
                            s_d.wr   = 1'b1;
                            s_d.st   = sync_now ? RX_ADDR : RX_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                        if (sdifs_i) s_d.pend = 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_valid_o = s_q.wr;
    assign wr_addr_o  = s_q.addr;
    assign wr_data_o  = s_q.data;
endmodule

// File: rtl/fsp_serial_port.sv
module fsp_serial_port #(
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              pwr_up_i,
    input  logic              adc_valid_i,
    input  logic [WORD_W-1:0] adc_addr_i,
    input  logic [WORD_W-1:0] adc_data_i,
    input  logic              rsm_valid_i,
    input  logic [WORD_W-1:0] rsm_addr_i,
    input  logic [WORD_W-1:0] rsm_data_i,
    input  logic              sdi_i,
    input  logic              sdifs_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              sdofs_o,
    output logic              out_en_o,
    output logic              wr_valid_o,
    output logic [WORD_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o
);
    logic sclk_rise, sclk_fall;
    logic tx_busy, adc_pend, src_adc;

    fsp_sclk_gen #(.HALF_DIV(HALF_DIV)) u_gen (
        .clk(clk), .rst_n(rst_n),
        .sclk_o(sclk_o), .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    fsp_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise_i(sclk_rise), .cs_i(cs_i),
        .pwr_up_i(pwr_up_i),
        .adc_valid_i(adc_valid_i), .adc_addr_i(adc_addr_i), .adc_data_i(adc_data_i),
        .rsm_valid_i(rsm_valid_i), .rsm_addr_i(rsm_addr_i), .rsm_data_i(rsm_data_i),
        .sdo_o(sdo_o), .sdofs_o(sdofs_o), .busy_o(tx_busy),
        .adc_pend_o(adc_pend), .src_adc_o(src_adc)
    );

    fsp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fall_i(sclk_fall), .cs_i(cs_i),
        .sdi_i(sdi_i), .sdifs_i(sdifs_i),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    assign out_en_o = cs_i & rst_n;
endmodule

// File: rtl/fsp_serial_port_chk.sv
module fsp_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_i,
    input logic pwr_up_i,
    input logic sclk_o,
    input logic sdo_o,
    input logic sdofs_o,
    input logic wr_valid_o,
    input logic tx_busy,
    input logic adc_pend,
    input logic src_adc
);
    // R1: outputs move only with a rising serial clock while selected
    p_edge_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && $past(cs_i) && $past(cs_i, 2) && !$rose(sclk_o))
            |-> ($stable(sdo_o) && $stable(sdofs_o)));

    // R3: write strobe lasts one system clock
    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R5: converter slot wins at a start
    p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_busy) && $past(adc_pend)) |-> src_adc);

    // R7: no start without power-up
    p_pwr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(pwr_up_i));

    // R8: deselect aborts the output pair
    p_cs_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> (!tx_busy && !sdofs_o));
endmodule

bind fsp_serial_port fsp_serial_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .pwr_up_i(pwr_up_i),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdofs_o(sdofs_o),
    .wr_valid_o(wr_valid_o), .tx_busy(tx_busy),
    .adc_pend(adc_pend), .src_adc(src_adc)
);

// File: tb/fsp_serial_port_bench.sv
module fsp_serial_port_bench;
    localparam int W = 16;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b1, pwr_up_i = 1'b0;
    logic adc_valid_i = 1'b0, rsm_valid_i = 1'b0;
    logic [W-1:0] adc_addr_i = '0, adc_data_i = '0, rsm_addr_i = '0, rsm_data_i = '0;
    logic sdi_i = 1'b0, sdifs_i = 1'b0;
    logic sclk_o, sdo_o, sdofs_o, out_en_o, wr_valid_o;
    logic [W-1:0] wr_addr_o, wr_data_o;

    always #10 clk = ~clk;

    fsp_serial_port #(.WORD_W(W), .HALF_DIV(HALF)) u_fsp_serial_port (.*);

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(input logic [W-1:0] a, input logic [W-1:0] d);
        return {a, d};
    endfunction

    // Host receiver for the output direction
    logic [31:0] tx_got[$];
    bit          tx_fs_ok[$];
    bit          h_act = 0, h_fs = 1;
    int          h_n = 0;
    logic [31:0] h_sh = '0;
    always @(negedge sclk_o) begin
        #1;
        if (!out_en_o) h_act = 0;
        else if (!h_act) begin
            if (sdofs_o) begin h_act = 1; h_n = 0; h_fs = 1; end
        end else begin
            h_sh = {h_sh[30:0], sdo_o};
            if (sdofs_o != (h_n == 15)) h_fs = 0;
            h_n++;
            if (h_n == 32) begin
                tx_got.push_back(h_sh);
                tx_fs_ok.push_back(h_fs);
                h_act = 0;
            end
        end
    end

    // Write strobe collector for the input direction
    logic [31:0] rx_got[$];
    int          wr_len = 0;
    always @(negedge clk) begin
        if (wr_valid_o) begin
            rx_got.push_back(pack(wr_addr_o, wr_data_o));
            if (u_prev_wr) wr_len++;
        end
        u_prev_wr = wr_valid_o;
    end
    bit u_prev_wr = 0;

    task automatic wait_rise();
        @(posedge sclk_o); #1;
    endtask

    task automatic post_adc(input logic [W-1:0] a, input logic [W-1:0] d);
        @(negedge clk); adc_valid_i = 1; adc_addr_i = a; adc_data_i = d;
        @(negedge clk); adc_valid_i = 0;
    endtask

    task automatic post_rsm(input logic [W-1:0] a, input logic [W-1:0] d);
        @(negedge clk); rsm_valid_i = 1; rsm_addr_i = a; rsm_data_i = d;
        @(negedge clk); rsm_valid_i = 0;
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 200 && tx_got.size() < n; i++) wait_rise();
    endtask

    // apos: bit index of the second sync inside the address (used when gap==0)
    // dpos: bit index of a sync inside the data word (chains the next pair), -1 none
    task automatic host_send(input logic [W-1:0] a, input logic [W-1:0] d,
                             input int apos, input int gap, input int dpos,
                             input bit skip_sync);
        if (!skip_sync) begin wait_rise(); sdifs_i = 1; sdi_i = 0; end
        for (int i = 0; i < W; i++) begin
            wait_rise(); sdifs_i = (gap == 0 && i == apos); sdi_i = a[W-1-i];
        end
        if (gap > 0) begin
            for (int g = 0; g < gap; g++) begin wait_rise(); sdifs_i = 0; sdi_i = 1'($urandom); end
            wait_rise(); sdifs_i = 1;
        end
        for (int i = 0; i < W; i++) begin
            wait_rise(); sdifs_i = (i == dpos); sdi_i = d[W-1-i];
        end
        if (dpos < 0) begin wait_rise(); sdifs_i = 0; sdi_i = 0; end
    endtask

    logic [31:0] exp_rx[$];

    initial begin
        logic [31:0] p;
        int t0, t1, t2;
        bit skip;
        void'($urandom(32'h5eed_1234));
        // R9 reset state
        repeat (3) @(negedge clk);
        check(out_en_o == 0, "R9", "out_en in reset", out_en_o, 0);
        check(wr_valid_o == 0, "R9", "wr_valid in reset", wr_valid_o, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(out_en_o == 1, "R9", "out_en after reset", out_en_o, 1);
        check(sdofs_o == 0, "R9", "sdofs after reset", sdofs_o, 0);

        // R1 serial clock period and duty
        @(posedge sclk_o); t0 = $time;
        @(negedge sclk_o); t1 = $time;
        @(posedge sclk_o); t2 = $time;
        check((t1 - t0) == HALF * 20, "R1", "sclk high time", t1 - t0, HALF * 20);
        check((t2 - t0) == 2 * HALF * 20, "R1", "sclk period", t2 - t0, 2 * HALF * 20);

        // R7 power-up gating
        post_adc(16'hA5C3, 16'h1234);
        repeat (80) wait_rise();
        check(tx_got.size() == 0, "R7", "frames while powered down", tx_got.size(), 0);
        pwr_up_i = 1;
        wait_frames(1);
        check(tx_got.size() == 1, "R7", "frame after power-up", tx_got.size(), 1);
        p = tx_got.pop_front();
        check(p == pack(16'hA5C3, 16'h1234), "R2", "pair bits", p, pack(16'hA5C3, 16'h1234));
        check(tx_fs_ok.pop_front() == 1, "R2", "sync placement", 0, 1);

        // R5 priority and R6 overwrite
        repeat (4) wait_rise();
        pwr_up_i = 0;
        repeat (4) wait_rise();
        post_rsm(16'h0101, 16'h0202);
        post_adc(16'h1111, 16'h2222);
        post_adc(16'h3333, 16'h4444);
        pwr_up_i = 1;
        wait_frames(2);
        repeat (80) wait_rise();
        check(tx_got.size() == 2, "R6", "frames after overwrite", tx_got.size(), 2);
        p = tx_got.pop_front();
        check(p == pack(16'h3333, 16'h4444), "R5", "first is converter (newest R6)", p, pack(16'h3333, 16'h4444));
        p = tx_got.pop_front();
        check(p == pack(16'h0101, 16'h0202), "R5", "second is resampler", p, pack(16'h0101, 16'h0202));
        tx_fs_ok.delete();

        // R5 pair in progress is not interrupted
        post_rsm(16'hBEEF, 16'hCAFE);
        @(posedge sdofs_o);
        repeat (3) wait_rise();
        post_adc(16'h7E57, 16'h0BAD);
        wait_frames(2);
        check(tx_got.size() == 2, "R5", "frame count", tx_got.size(), 2);
        p = tx_got.pop_front();
        check(p == pack(16'hBEEF, 16'hCAFE), "R5", "running pair intact", p, pack(16'hBEEF, 16'hCAFE));
        p = tx_got.pop_front();
        check(p == pack(16'h7E57, 16'h0BAD), "R5", "later converter pair", p, pack(16'h7E57, 16'h0BAD));
        while (tx_fs_ok.size() > 0) check(tx_fs_ok.pop_front() == 1, "R2", "sync placement", 0, 1);

        // R8 chip select mid-pair
        post_adc(16'hDEAD, 16'h0001);
        @(posedge sdofs_o);
        repeat (10) wait_rise();
        cs_i = 0;
        @(negedge clk);
        check(out_en_o == 0, "R8", "out_en with cs low", out_en_o, 0);
        repeat (5) wait_rise();
        cs_i = 1;
        repeat (90) wait_rise();
        check(tx_got.size() == 0, "R8", "aborted pair lost", tx_got.size(), 0);
        post_adc(16'h0F0F, 16'hF0F0);
        wait_frames(1);
        p = (tx_got.size() > 0) ? tx_got.pop_front() : '0;
        check(p == pack(16'h0F0F, 16'hF0F0), "R8", "next pair after abort", p, pack(16'h0F0F, 16'hF0F0));
        tx_fs_ok.delete();
        pwr_up_i = 0;

        // R3 basic input pair, sync at address LSB
        host_send(16'h8001, 16'h4003, 15, 0, -1, 0);
        repeat (3) wait_rise();
        check(rx_got.size() == 1, "R3", "write count", rx_got.size(), 1);
        p = (rx_got.size() > 0) ? rx_got.pop_front() : '0;
        check(p == pack(16'h8001, 16'h4003), "R3", "received pair", p, pack(16'h8001, 16'h4003));

        // R4 early sync inside the address is held to the LSB
        host_send(16'h1357, 16'h2468, 3, 0, -1, 0);
        repeat (3) wait_rise();
        p = (rx_got.size() > 0) ? rx_got.pop_front() : '0;
        check(p == pack(16'h1357, 16'h2468), "R4", "early sync deferred", p, pack(16'h1357, 16'h2468));

        // R4 sync after a gap
        host_send(16'hFACE, 16'h00FF, -1, 5, -1, 0);
        repeat (3) wait_rise();
        p = (rx_got.size() > 0) ? rx_got.pop_front() : '0;
        check(p == pack(16'hFACE, 16'h00FF), "R4", "gap before data sync", p, pack(16'hFACE, 16'h00FF));

        // R8 input ignored while deselected, and word in flight dropped
        wait_rise(); sdifs_i = 1;
        for (int i = 0; i < 8; i++) begin wait_rise(); sdifs_i = 0; sdi_i = 1; end
        cs_i = 0;
        for (int i = 0; i < 40; i++) begin wait_rise(); sdifs_i = (i % 17 == 0); sdi_i = 1'($urandom); end
        sdifs_i = 0;
        repeat (3) wait_rise();
        cs_i = 1;
        repeat (3) wait_rise();
        check(rx_got.size() == 0, "R8", "writes while deselected", rx_got.size(), 0);
        host_send(16'h2BAD, 16'h600D, 15, 0, -1, 0);
        repeat (3) wait_rise();
        check(rx_got.size() == 1, "R8", "writes after reselect", rx_got.size(), 1);
        p = (rx_got.size() > 0) ? rx_got.pop_front() : '0;
        check(p == pack(16'h2BAD, 16'h600D), "R8", "clean pair after reselect", p, pack(16'h2BAD, 16'h600D));

        // R4 chained pairs, random placements
        skip = 0;
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] a, d;
            int apos, gap, dpos;
            a = W'($urandom); d = W'($urandom);
            gap  = ($urandom % 4 == 0) ? 1 + int'($urandom % 4) : 0;
            apos = int'($urandom % 16);
            dpos = (k < 15 && $urandom % 2 == 0) ? int'($urandom % 16) : -1;
            exp_rx.push_back(pack(a, d));
            host_send(a, d, apos, gap, dpos, skip);
            skip = (dpos >= 0);
        end
        repeat (3) wait_rise();
        check(rx_got.size() == exp_rx.size(), "R4", "random write count", rx_got.size(), exp_rx.size());
        while (exp_rx.size() > 0 && rx_got.size() > 0) begin
            logic [31:0] e;
            e = exp_rx.pop_front(); p = rx_got.pop_front();
            check(p == e, "R4", "random chained pair", p, e);
        end
        check(wr_len == 0, "R3", "strobe longer than one clock", wr_len, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule